// File: doc/BRIEF.md
# YCbCr 4:2:2 Capture Port with Planar FIFOs

This block receives an 8-bit interleaved YCbCr 4:2:2 sample stream, one byte per clock, with horizontal sync, vertical sync and a line-valid strobe. A horizontal sample counter and a vertical line counter restart on the rising edges of the syncs. Together they place every sample in a programmable rectangular window. Samples inside the window are sorted by their position in the Cb, Y, Cr, Y sequence into three planes: luma, blue chroma and red chroma. Each plane is packed little-endian into 64-bit words and stored in its own FIFO.

Each FIFO raises a read request while it holds at least a programmed number of words. The luma plane uses the programmed threshold and both chroma planes use half of it. A downstream transfer engine drains the FIFOs one word per strobe. A word that arrives at a full FIFO is dropped and sets a sticky overrun flag. Samples inside the window that arrive while line-valid is low are stored as zero.

A configuration check rejects window and threshold settings for which a line of any plane does not divide into whole threshold blocks. Capture only begins at a vertical sync while the block is enabled and the configuration is accepted. Operation is progressive, with one field per frame.

Top module: `vcap_port`

## Requirements
- R1: The sample on the clock where hsync rises has horizontal position 0, and the position counts up by one each clock after that. The line number becomes 0 where vsync rises and increases by one at every hsync rise, so the first line after vsync is line 1.
- R2: A sample is captured only when its position lies in x_start..x_stop and its line lies in y_start..y_stop. All four bounds are inclusive. Samples outside the window leave every FIFO unchanged.
- R3: Inside the window, samples follow the order Cb, Y, Cr, Y, restarting at x_start. Y goes to plane 0, Cb to plane 1 and Cr to plane 2. Each plane index is the bit index in rd_pop and rd_req.
- R4: The bytes of a plane are packed into 64-bit words with the earliest byte in bits 7:0. A line ends at x_stop; any partial word is zero-padded and stored at that point.
- R5: A sample inside the window that arrives while vid_lvalid is low is stored as byte 0x00.
- R6: rd_req[0] is high while the luma FIFO holds at least thr words (and at least one word). rd_req[1] and rd_req[2] use thr/2 instead. The request and the data for a word are visible one clock after the edge that captures its last byte.
- R7: The luma FIFO holds 160 words and each chroma FIFO holds 80 words. The rdata output of a plane shows its oldest word, and a high rd_pop bit removes that word at the next edge.
- R8: cfg_err is high when any of these holds: thr is 0 or odd; x_stop < x_start; y_stop < y_start; the window width W = x_stop-x_start+1 is not a multiple of 4; W/2 is not a multiple of 8*thr. While cfg_err is high, no sample is captured. Capture starts only at a vsync rise while enable is 1 and cfg_err is 0.
- R9: A word that arrives while its FIFO is full is dropped, and ovr_flag rises the clock after. ovr_flag stays high until a write to register 0 with bit 1 set clears it.
- R10: frame_start pulses high for one clock, one clock after the first captured sample of each frame. It does not pulse in a frame where nothing is captured.
- R11: After reset, rd_req, ovr_flag and frame_start are low. cfg_err is high because thr resets to 0.
- R12: Configuration registers are written on cfg_we: address 0 holds control (bit 0 enables capture, bit 1 clears overrun), 1 holds x_start, 2 x_stop, 3 y_start, 4 y_stop and 5 thr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, one sample per clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_hsync | input | 1 | Horizontal sync, rising edge restarts the sample counter |
| vid_vsync | input | 1 | Vertical sync, rising edge restarts the line counter |
| vid_lvalid | input | 1 | Line-valid strobe; low forces stored bytes to zero |
| vid_data | input | 8 | Interleaved YCbCr sample |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| rd_pop | input | 3 | Per-plane pop strobe (0 Y, 1 Cb, 2 Cr) |
| y_rdata | output | 64 | Oldest luma word |
| cb_rdata | output | 64 | Oldest Cb word |
| cr_rdata | output | 64 | Oldest Cr word |
| rd_req | output | 3 | Per-plane threshold request |
| ovr_flag | output | 1 | Sticky overrun flag |
| cfg_err | output | 1 | Configuration rejected |
| frame_start | output | 1 | One-clock pulse at the first captured sample of a frame |

## Verification
A word lands in its FIFO on the edge that captures its eighth byte, or on the edge at x_stop. Its request bit and its data are valid one clock later, so the bench drives every frame completely, adds blanking clocks, and only then samples rd_req and the read data on falling edges. A pop takes effect at the next rising edge, so each read check is made on the falling edge after the previous pop. frame_start and ovr_flag settle one clock after the sample that causes them; the bench counts frame_start pulses on falling edges across a whole frame, and reads ovr_flag after the frame.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

  typedef enum logic [1:0] {
    PL_Y  = 2'd0,
    PL_CB = 2'd1,
    PL_CR = 2'd2
  } plane_e;

  localparam int NPLANE   = 3;
  localparam int WORD_W   = 64;
  localparam int LANES    = WORD_W / 8;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_XS   = 3'd1;
  localparam logic [2:0] REG_XE   = 3'd2;
  localparam logic [2:0] REG_YS   = 3'd3;
  localparam logic [2:0] REG_YE   = 3'd4;
  localparam logic [2:0] REG_THR  = 3'd5;

  function automatic plane_e plane_of(input int idx);
    case (idx)
      0:       return PL_Y;
      1:       return PL_CB;
      default: return PL_CR;
    endcase
  endfunction

endpackage

// File: rtl/vcap_window.sv
module vcap_window import vcap_pkg::*; #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync,
  input  logic          vsync,
  input  logic          lvalid,
  input  logic [7:0]    din,
  input  logic          run_en,
  input  logic [CW-1:0] x_start,
  input  logic [CW-1:0] x_stop,
  input  logic [CW-1:0] y_start,
  input  logic [CW-1:0] y_stop,
  output logic          smp_vld,
  output plane_e        smp_plane,
  output logic [7:0]    smp_byte,
  output logic          line_end,
  output logic          frame_start
);

  logic          hs_q, vs_q;
  logic [CW-1:0] hcnt_q, hcnt_d, vcnt_q, vcnt_d, x_cur, y_cur;
  logic [1:0]    ph_q, ph_d, ph_cur;
  logic          run_q, run_d, run_cur;
  logic          armed_q, armed_d, armed_eff;
  logic          fs_q, fs_d;
  logic          h_start, v_start, in_win;

  always_comb begin
    h_start = hsync & ~hs_q;
    v_start = vsync & ~vs_q;
    x_cur   = h_start ? '0 : hcnt_q;
    hcnt_d  = (&x_cur) ? x_cur : x_cur + 1'b1;
    if (v_start)      y_cur = '0;
    else if (h_start) y_cur = (&vcnt_q) ? vcnt_q : vcnt_q + 1'b1;
    else              y_cur = vcnt_q;
    vcnt_d    = y_cur;
    run_cur   = v_start ? run_en : (run_q & run_en);
    run_d     = run_cur;
    in_win    = run_cur && (x_cur >= x_start) && (x_cur <= x_stop) &&
                (y_cur >= y_start) && (y_cur <= y_stop);
    ph_cur    = (x_cur == x_start) ? 2'd0 : ph_q;
    ph_d      = ph_cur + 2'd1;
    armed_eff = v_start | armed_q;
    armed_d   = armed_eff & ~in_win;
    fs_d      = in_win & armed_eff;
  end

  always_comb begin
    case (ph_cur)
      2'd0:    smp_plane = PL_CB;
      2'd2:    smp_plane = PL_CR;
      default: smp_plane = PL_Y;
    endcase
    smp_vld     = in_win;
    smp_byte    = lvalid ? din : 8'h00;
    line_end    = in_win && (x_cur == x_stop);
    frame_start = fs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
      hcnt_q  <= '0;
      vcnt_q  <= '0;
      ph_q    <= 2'd0;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      fs_q    <= 1'b0;
    end else begin
      hs_q    <= hsync;
      vs_q    <= vsync;
      hcnt_q  <= hcnt_d;
      vcnt_q  <= vcnt_d;
      if (in_win) ph_q <= ph_d;
      run_q   <= run_d;
      armed_q <= armed_d;
      fs_q    <= fs_d;
    end
  end

  AST_HCNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    h_start |=> (hcnt_q == CW'(1))); // R1

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && $past(in_win) && (x_cur != x_start)) |->
      (ph_cur == $past(ph_cur) + 2'd1)); // R3

  AST_RUN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(run_en)); // R8

endmodule

// File: rtl/vcap_packer.sv
module vcap_packer import vcap_pkg::*; #(
  parameter plane_e PLANE = PL_Y
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  plane_e            smp_plane,
  input  logic [7:0]        smp_byte,
  input  logic              line_end,
  output logic              push,
  output logic [WORD_W-1:0] word
);

  logic [2:0]        lane_q;
  logic [WORD_W-1:0] acc_q, acc_n;
  logic              wr;
  logic [3:0]        fill;

  assign wr = smp_vld && (smp_plane == PLANE);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign acc_n[8*i +: 8] = (wr && (lane_q == 3'(i))) ? smp_byte : acc_q[8*i +: 8];
  end

  always_comb begin
    fill = {1'b0, lane_q} + {3'b000, wr};
    push = (fill == 4'd8) || (line_end && (fill != 4'd0));
    word = acc_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      lane_q <= 3'd0;
    end else if (push) begin
      acc_q  <= '0;
      lane_q <= 3'd0;
    end else if (wr) begin
      acc_q  <= acc_n;
      lane_q <= lane_q + 3'd1;
    end
  end

  AST_LINE_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (lane_q == 3'd0)); // R4

endmodule

// File: rtl/vcap_fifo.sv
module vcap_fifo #(
  parameter int DEPTH = 160,
  parameter int CNTW  = 8,
  parameter int WW    = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [WW-1:0]   wdata,
  input  logic            pop,
  input  logic [CNTW-1:0] thr,
  input  logic            ovr_clr,
  output logic [WW-1:0]   rdata,
  output logic            req,
  output logic            ovr
);

  localparam int AW = $clog2(DEPTH);

  logic [WW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            ovr_q, ovr_d;
  logic            full, empty, do_push, do_pop;

  always_comb begin
    full    = (cnt_q == CNTW'(DEPTH));
    empty   = (cnt_q == '0);
    do_push = push && !full;
    do_pop  = pop && !empty;
    wptr_d  = (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
    rptr_d  = (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    if (push && full) ovr_d = 1'b1;
    else if (ovr_clr) ovr_d = 1'b0;
    else              ovr_d = ovr_q;
  end

  assign rdata = mem[rptr_q];
  assign req   = !empty && (cnt_q >= thr);
  assign ovr   = ovr_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (do_push) wptr_q <= wptr_d;
      if (do_pop)  rptr_q <= rptr_d;
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt_q == $past(cnt_q))); // R9

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> ovr_q); // R9

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ovr_clr) |=> ovr_q); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(DEPTH)); // R7

endmodule

// File: rtl/vcap_port.sv
module vcap_port import vcap_pkg::*; #(
  parameter int CW      = 12,
  parameter int Y_DEPTH = 160,
  parameter int C_DEPTH = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vid_hsync,
  input  logic              vid_vsync,
  input  logic              vid_lvalid,
  input  logic [7:0]        vid_data,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  input  logic [2:0]        rd_pop,
  output logic [WORD_W-1:0] y_rdata,
  output logic [WORD_W-1:0] cb_rdata,
  output logic [WORD_W-1:0] cr_rdata,
  output logic [2:0]        rd_req,
  output logic              ovr_flag,
  output logic              cfg_err,
  output logic              frame_start
);

  localparam int CNTW = $clog2(Y_DEPTH + 1);

  logic            rs1_q, rs2_q, srst_n;
  logic            en_q, en_d;
  logic [CW-1:0]   xs_q, xs_d, xe_q, xe_d, ys_q, ys_d, ye_q, ye_d;
  logic [CNTW-1:0] thr_q, thr_d;
  logic [CW:0]     width_w, div_w, luma_b;
  logic            ovr_clr;
  logic            smp_vld, line_end;
  plane_e          smp_plane;
  logic [7:0]      smp_byte;
  logic [WORD_W-1:0] rdata_a [NPLANE];
  logic [NPLANE-1:0] ovr_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign srst_n = rs2_q;

  always_comb begin
    en_d  = en_q;
    xs_d  = xs_q;
    xe_d  = xe_q;
    ys_d  = ys_q;
    ye_d  = ye_q;
    thr_d = thr_q;
    if (cfg_we) begin
      case (cfg_addr)
        REG_CTRL: en_d  = cfg_wdata[0];
        REG_XS:   xs_d  = cfg_wdata[CW-1:0];
        REG_XE:   xe_d  = cfg_wdata[CW-1:0];
        REG_YS:   ys_d  = cfg_wdata[CW-1:0];
        REG_YE:   ye_d  = cfg_wdata[CW-1:0];
        REG_THR:  thr_d = cfg_wdata[CNTW-1:0];
        default:  ;
      endcase
    end
    ovr_clr = cfg_we && (cfg_addr == REG_CTRL) && cfg_wdata[1];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      en_q  <= 1'b0;
      xs_q  <= '0;
      xe_q  <= '0;
      ys_q  <= '0;
      ye_q  <= '0;
      thr_q <= '0;
    end else begin
      en_q  <= en_d;
      xs_q  <= xs_d;
      xe_q  <= xe_d;
      ys_q  <= ys_d;
      ye_q  <= ye_d;
      thr_q <= thr_d;
    end
  end

  always_comb begin
    width_w = {1'b0, xe_q} - {1'b0, xs_q} + (CW+1)'(1);
    luma_b  = width_w >> 1;
    div_w   = (thr_q == '0) ? (CW+1)'(8) : (CW+1)'({thr_q, 3'b000});
    cfg_err = (thr_q == '0) | thr_q[0] | (xe_q < xs_q) | (ye_q < ys_q) |
              (width_w[1:0] != 2'b00) | ((luma_b % div_w) != '0);
  end

  vcap_window #(.CW(CW)) u_window (
    .clk         (clk),
    .rst_n       (srst_n),
    .hsync       (vid_hsync),
    .vsync       (vid_vsync),
    .lvalid      (vid_lvalid),
    .din         (vid_data),
    .run_en      (en_q & ~cfg_err),
    .x_start     (xs_q),
    .x_stop      (xe_q),
    .y_start     (ys_q),
    .y_stop      (ye_q),
    .smp_vld     (smp_vld),
    .smp_plane   (smp_plane),
    .smp_byte    (smp_byte),
    .line_end    (line_end),
    .frame_start (frame_start)
  );

  for (genvar p = 0; p < NPLANE; p++) begin : g_plane
    localparam int DEPTH = (p == 0) ? Y_DEPTH : C_DEPTH;
    logic              push;
    logic [WORD_W-1:0] word;
    logic [CNTW-1:0]   thr_p;

    assign thr_p = (p == 0) ? thr_q : (thr_q >> 1);

    vcap_packer #(.PLANE(plane_of(p))) u_pack (
      .clk       (clk),
      .rst_n     (srst_n),
      .smp_vld   (smp_vld),
      .smp_plane (smp_plane),
      .smp_byte  (smp_byte),
      .line_end  (line_end),
      .push      (push),
      .word      (word)
    );

    vcap_fifo #(.DEPTH(DEPTH), .CNTW(CNTW), .WW(WORD_W)) u_fifo (
      .clk     (clk),
      .rst_n   (srst_n),
      .push    (push),
      .wdata   (word),
      .pop     (rd_pop[p]),
      .thr     (thr_p),
      .ovr_clr (ovr_clr),
      .rdata   (rdata_a[p]),
      .req     (rd_req[p]),
      .ovr     (ovr_a[p])
    );
  end

  assign y_rdata  = rdata_a[0];
  assign cb_rdata = rdata_a[1];
  assign cr_rdata = rdata_a[2];
  assign ovr_flag = |ovr_a;

  AST_NO_CAPTURE_ON_ERR: assert property (@(posedge clk) disable iff (!srst_n)
    cfg_err |=> !frame_start); // R8

endmodule

// File: tb/vcap_port_bench.sv
module vcap_port_bench;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        vid_hsync, vid_vsync, vid_lvalid;
  logic [7:0]  vid_data;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic [2:0]  rd_pop;
  logic [63:0] y_rdata, cb_rdata, cr_rdata;
  logic [2:0]  rd_req;
  logic        ovr_flag, cfg_err, frame_start;

  int checks = 0;
  int errors = 0;
  int fs_cnt = 0;
  logic [63:0] eq_y[$];
  logic [63:0] eq_cb[$];
  logic [63:0] eq_cr[$];

  always #(PERIOD/2) clk = ~clk;

  vcap_port u_vcap_port (
    .clk(clk), .rst_n(rst_n), .vid_hsync(vid_hsync), .vid_vsync(vid_vsync),
    .vid_lvalid(vid_lvalid), .vid_data(vid_data), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_pop(rd_pop),
    .y_rdata(y_rdata), .cb_rdata(cb_rdata), .cr_rdata(cr_rdata),
    .rd_req(rd_req), .ovr_flag(ovr_flag), .cfg_err(cfg_err),
    .frame_start(frame_start)
  );

  always @(negedge clk) if (frame_start) fs_cnt++;

  function automatic logic [7:0] val(int l, int x);
    return 8'(l * 37 + x * 3 + 1);
  endfunction

  function automatic logic [63:0] rdata_of(int p);
    if (p == 0) return y_rdata;
    if (p == 1) return cb_rdata;
    return cr_rdata;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(logic [2:0] a, logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_win(int xs, int xe, int ys, int ye, int thr);
    wr_cfg(3'd1, 16'(xs)); wr_cfg(3'd2, 16'(xe));
    wr_cfg(3'd3, 16'(ys)); wr_cfg(3'd4, 16'(ye));
    wr_cfg(3'd5, 16'(thr));
  endtask

  task automatic push_exp(int p, logic [63:0] w);
    if (p == 0) eq_y.push_back(w);
    else if (p == 1) eq_cb.push_back(w);
    else eq_cr.push_back(w);
  endtask

  task automatic model_frame(int xs, int xe, int ys, int ye, int lv_len);
    logic [63:0] acc [3];
    int ln [3];
    for (int l = ys; l <= ye; l++) begin
      for (int p = 0; p < 3; p++) begin acc[p] = '0; ln[p] = 0; end
      for (int x = xs; x <= xe; x++) begin
        int ph = (x - xs) % 4;
        int p = (ph == 0) ? 1 : ((ph == 2) ? 2 : 0);
        acc[p][ln[p]*8 +: 8] = (x < lv_len) ? val(l, x) : 8'h00;
        ln[p]++;
        if (ln[p] == 8) begin push_exp(p, acc[p]); acc[p] = '0; ln[p] = 0; end
      end
      for (int p = 0; p < 3; p++) if (ln[p] != 0) push_exp(p, acc[p]);
    end
  endtask

  task automatic drive_frame(int nl, int llen, int lv_len);
    fs_cnt = 0;
    vid_vsync = 1'b1; vid_hsync = 1'b0; vid_lvalid = 1'b0; vid_data = 8'h00;
    @(negedge clk);
    vid_vsync = 1'b0;
    repeat (2) @(negedge clk);
    for (int l = 1; l <= nl; l++) begin
      for (int x = 0; x < llen; x++) begin
        vid_hsync  = (x == 0);
        vid_lvalid = (x < lv_len);
        vid_data   = val(l, x);
        @(negedge clk);
      end
      vid_hsync = 1'b0; vid_lvalid = 1'b0; vid_data = 8'h00;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic pop_check(int p, int n, string tag);
    for (int i = 0; i < n; i++) begin
      logic [63:0] exp;
      logic [63:0] act = rdata_of(p);
      if (p == 0) exp = (eq_y.size() > 0) ? eq_y.pop_front() : '0;
      else if (p == 1) exp = (eq_cb.size() > 0) ? eq_cb.pop_front() : '0;
      else exp = (eq_cr.size() > 0) ? eq_cr.pop_front() : '0;
      chk(act == exp, tag, act, exp);
      rd_pop = 3'(1 << p);
      @(negedge clk);
      rd_pop = 3'b000;
    end
  endtask

  task automatic t_reset();
    chk(rd_req == 3'b000, "R11 rd_req after reset", 64'(rd_req), 64'h0);
    chk(ovr_flag == 1'b0, "R11 ovr_flag after reset", 64'(ovr_flag), 64'h0);
    chk(frame_start == 1'b0, "R11 frame_start after reset", 64'(frame_start), 64'h0);
    chk(cfg_err == 1'b1, "R11 cfg_err with thr 0", 64'(cfg_err), 64'h1);
  endtask

  task automatic t_basic();
    // R12 register map; window W=64, two lines, thr 2
    set_win(4, 67, 2, 3, 2);
    wr_cfg(3'd0, 16'h0001);
    chk(cfg_err == 1'b0, "R8 valid config accepted", 64'(cfg_err), 64'h0);
    model_frame(4, 67, 2, 3, 72);
    drive_frame(3, 72, 72);
    chk(fs_cnt == 1, "R10 one frame_start per frame", 64'(fs_cnt), 64'h1);
    chk(rd_req == 3'b111, "R6 requests after two lines", 64'(rd_req), 64'h7);
    // R3 R4: first Cb byte is sample x_start of line 2 in bits 7:0
    chk(cb_rdata[7:0] == val(2, 4), "R3 R4 first Cb lane", 64'(cb_rdata[7:0]), 64'(val(2, 4)));
    chk(y_rdata[7:0] == val(2, 5), "R3 R4 first Y lane", 64'(y_rdata[7:0]), 64'(val(2, 5)));
    pop_check(0, 6, "R2 R7 luma data");
    chk(rd_req[0] == 1'b1, "R6 luma req at 2 words", 64'(rd_req[0]), 64'h1);
    pop_check(0, 1, "R7 luma data");
    chk(rd_req[0] == 1'b0, "R6 luma req below thr", 64'(rd_req[0]), 64'h0);
    pop_check(0, 1, "R7 luma last");
    pop_check(1, 3, "R3 Cb data");
    chk(rd_req[1] == 1'b1, "R6 Cb req at thr/2", 64'(rd_req[1]), 64'h1);
    pop_check(1, 1, "R3 Cb last");
    chk(rd_req[1] == 1'b0, "R6 Cb req empty", 64'(rd_req[1]), 64'h0);
    pop_check(2, 4, "R3 Cr data");
    chk(rd_req == 3'b000, "R2 nothing beyond window", 64'(rd_req), 64'h0);
  endtask

  task automatic t_short_lvalid();
    // window starts at the hsync sample (R1), line 1 only, lvalid ends at x=20
    set_win(0, 31, 1, 1, 2);
    model_frame(0, 31, 1, 1, 20);
    drive_frame(2, 36, 20);
    chk(rd_req[0] == 1'b1, "R1 line 1 captured", 64'(rd_req[0]), 64'h1);
    chk(y_rdata[7:0] == val(1, 1), "R1 position 0 at hsync", 64'(y_rdata[7:0]), 64'(val(1, 1)));
    pop_check(0, 2, "R5 luma zero fill");
    pop_check(1, 1, "R5 Cb zero fill");
    pop_check(2, 1, "R5 Cr zero fill");
    chk(rd_req == 3'b000, "R5 drained", 64'(rd_req), 64'h0);
  endtask

  task automatic t_cfg_err();
    set_win(4, 67, 2, 3, 3);
    chk(cfg_err == 1'b1, "R8 odd thr rejected", 64'(cfg_err), 64'h1);
    drive_frame(3, 72, 72);
    chk(rd_req == 3'b000, "R8 no capture on error", 64'(rd_req), 64'h0);
    chk(fs_cnt == 0, "R10 R8 no frame_start on error", 64'(fs_cnt), 64'h0);
    set_win(0, 39, 2, 3, 2);
    chk(cfg_err == 1'b1, "R8 width not multiple of block", 64'(cfg_err), 64'h1);
    set_win(8, 4, 2, 3, 2);
    chk(cfg_err == 1'b1, "R8 x_stop below x_start", 64'(cfg_err), 64'h1);
    set_win(0, 31, 2, 3, 2);
    chk(cfg_err == 1'b0, "R8 config accepted again", 64'(cfg_err), 64'h0);
  endtask

  task automatic t_overrun();
    set_win(4, 67, 1, 40, 2);
    model_frame(4, 67, 1, 40, 72);
    drive_frame(40, 72, 72);
    chk(ovr_flag == 1'b0, "R9 exactly full no overrun", 64'(ovr_flag), 64'h0);
    set_win(4, 67, 1, 1, 2);
    drive_frame(1, 72, 72);
    chk(ovr_flag == 1'b1, "R9 overrun set", 64'(ovr_flag), 64'h1);
    drive_frame(0, 72, 72);
    chk(ovr_flag == 1'b1, "R9 overrun sticky", 64'(ovr_flag), 64'h1);
    pop_check(0, 160, "R9 R7 luma kept, extra dropped");
    pop_check(1, 80, "R9 R7 Cb kept");
    pop_check(2, 80, "R9 R7 Cr kept");
    chk(rd_req == 3'b000, "R7 drained after 160/80", 64'(rd_req), 64'h0);
    wr_cfg(3'd0, 16'h0003);
    chk(ovr_flag == 1'b0, "R9 overrun cleared", 64'(ovr_flag), 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    vid_hsync = 1'b0; vid_vsync = 1'b0; vid_lvalid = 1'b0; vid_data = 8'h00;
    cfg_we = 1'b0; cfg_addr = 3'd0; cfg_wdata = 16'h0; rd_pop = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_short_lvalid();
    t_cfg_err();
    t_overrun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule